// File: doc/BRIEF.md
# Host Bridge CPU Address Decoder

This block sits between a 32-bit CPU bus and a PCI host bridge. It decodes each CPU access and selects one target: PCI I/O space, PCI configuration space, the interrupt-acknowledge location, PCI memory space, the boot ROM, or "unmapped". For the selected target it also produces the translated address that the bridge should issue. A level-sensitive mode pin picks between two translations for the low 8 MB of I/O space. In the dense translation, that window folds onto a 64 KB port space. In the sparse translation, each 4 KB CPU page carries one 32-byte group of ports.

The decode is combinational. Its result is captured on the clock edge that follows a valid request. It is presented for one cycle with `dec_valid`, together with the copied direction and size. A read of the interrupt-acknowledge byte also raises a one-cycle strobe toward the interrupt controller. A bus that sees the unmapped select returns all-ones on reads and discards writes.

Top module: `hb_cpu_decoder`

## Requirements
- R1: An address from 0x80000000 to 0xBF7FFFFF that falls in neither the configuration window nor the low 8 MB I/O window selects PCI I/O. This is `dec_sel` bit 0. The translated address is the CPU address minus 0x80000000.
- R2: With `io_sparse` low, an address from 0x80000000 to 0x807FFFFF selects PCI I/O (bit 0). The translated address is the CPU address masked to its low 16 bits.
- R3: With `io_sparse` high, an address from 0x80000000 to 0x807FFFFF selects PCI I/O (bit 0). The translated address places CPU address bits [22:12] at bits [15:5] and keeps CPU bits [4:0] at bits [4:0]. Unaligned addresses are accepted. The pin is taken from the same cycle as each request, so it may change between requests.
- R4: An address from 0x80800000 to 0x80BFFFFF selects configuration space (bit 1), which takes priority over R1. The translated address keeps CPU bits [10:0] at bits [10:0]. It puts a device number at bits [15:11]: the index (0 to 10) of the lowest set bit among CPU bits [21:11], counted from bit 11. All upper bits are zero.
- R5: A configuration access with none of CPU bits [21:11] set yields device number 11.
- R6: A one-byte read of 0xBFFFFFF0 selects interrupt acknowledge (bit 2), with translated address 0. It raises `intack_strobe` together with that result for exactly one cycle. A write, or a wider access, to that address selects unmapped and raises no strobe.
- R7: An address from 0xC0000000 to 0xFEFFFFFF selects PCI memory (bit 3). The translated address is the CPU address minus 0xC0000000.
- R8: A read from 0xFFF00000 to 0xFFFFFFFF selects the boot ROM (bit 4), with translated address equal to CPU bits [19:0]. A write in that range selects unmapped, so it is dropped.
- R9: Every other access selects unmapped (bit 5), with translated address 0. This includes any request with size code 3. Size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.
- R10: `dec_valid` is high exactly in the cycle after a cycle with `req_valid` high. In that cycle `dec_write` and `dec_size` repeat the request's values. A synchronous reset clears `dec_valid`, `dec_sel` and `intack_strobe`.
- R11: Whenever `dec_valid` is high, exactly one bit of `dec_sel` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | CPU access present this cycle |
| req_addr | input | 32 | CPU byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| io_sparse | input | 1 | Low 8 MB I/O translation: 0 dense, 1 sparse |
| dec_valid | output | 1 | Decoded result valid |
| dec_sel | output | 6 | One-hot target: 0 I/O, 1 config, 2 int-ack, 3 memory, 4 ROM, 5 unmapped |
| dec_addr | output | 32 | Translated target address |
| dec_write | output | 1 | Registered copy of req_write |
| dec_size | output | 2 | Registered copy of req_size |
| intack_strobe | output | 1 | One-cycle interrupt-acknowledge pulse |

## Verification
The decoder is driven at the exact edges of every window, one address on each side, so that an off-by-one or a wrong priority between overlapping windows shows up as a wrong select. Configuration addresses with a single device bit, with several bits set, and with no bit set separate a lowest-bit scan from a highest-bit scan and expose a missing default. The same low-window addresses are repeated with the mode pin toggled from one request to the next. This shows whether the pin is sampled per access and whether the sparse packing puts page bits in the right place. Writes, wide accesses and illegal sizes aimed at the ROM and interrupt-acknowledge locations confirm that only the allowed access kinds reach those targets. Randomised addresses across the whole space then fill in the gaps.

// File: rtl/hb_cpu_decoder.sv
module hb_cpu_decoder #(
  parameter int AW = 32,
  parameter int NSEL = 6,
  parameter int DEVBITS = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic [1:0]      req_size,
  input  logic            io_sparse,
  output logic            dec_valid,
  output logic [NSEL-1:0] dec_sel,
  output logic [AW-1:0]   dec_addr,
  output logic            dec_write,
  output logic [1:0]      dec_size,
  output logic            intack_strobe
);
  localparam int S_IO = 0, S_CFG = 1, S_ACK = 2, S_MEM = 3, S_ROM = 4, S_NONE = 5;
  localparam logic [AW-1:0] IO_LO  = 32'h8000_0000, IO_HI  = 32'hBF7F_FFFF;
  localparam logic [AW-1:0] CFG_LO = 32'h8080_0000, CFG_HI = 32'h80BF_FFFF;
  localparam logic [AW-1:0] ACK_AD = 32'hBFFF_FFF0;
  localparam logic [AW-1:0] MEM_LO = 32'hC000_0000, MEM_HI = 32'hFEFF_FFFF;
  localparam logic [AW-1:0] ROM_LO = 32'hFFF0_0000;
  localparam logic [AW-1:0] LOW_HI = 32'h807F_FFFF;

  logic [NSEL-1:0] sel;
  logic [AW-1:0]   xaddr;
  logic [4:0]      dev;

  always_comb begin
    dev = 5'(DEVBITS);
    for (int i = DEVBITS - 1; i >= 0; i--)
      if (req_addr[11+i]) dev = 5'(i);
  end

  always_comb begin
    sel   = '0;
    xaddr = '0;
    if (req_size == 2'b11) begin
      sel[S_NONE] = 1'b1;
    end else if (req_addr >= CFG_LO && req_addr <= CFG_HI) begin
      sel[S_CFG] = 1'b1;
      xaddr = {16'b0, dev, req_addr[10:0]};
    end else if (req_addr >= IO_LO && req_addr <= LOW_HI) begin
      sel[S_IO] = 1'b1;
      xaddr = io_sparse ? {16'b0, req_addr[22:12], req_addr[4:0]}
                        : {16'b0, req_addr[15:0]};
    end else if (req_addr >= IO_LO && req_addr <= IO_HI) begin
      sel[S_IO] = 1'b1;
      xaddr = req_addr - IO_LO;
    end else if (req_addr == ACK_AD) begin
      if (!req_write && req_size == 2'b00) sel[S_ACK] = 1'b1;
      else sel[S_NONE] = 1'b1;
    end else if (req_addr >= MEM_LO && req_addr <= MEM_HI) begin
      sel[S_MEM] = 1'b1;
      xaddr = req_addr - MEM_LO;
    end else if (req_addr >= ROM_LO && !req_write) begin
      sel[S_ROM] = 1'b1;
      xaddr = {12'b0, req_addr[19:0]};
    end else begin
      sel[S_NONE] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid     <= 1'b0;
      dec_sel       <= '0;
      dec_addr      <= '0;
      dec_write     <= 1'b0;
      dec_size      <= 2'b00;
      intack_strobe <= 1'b0;
    end else begin
      dec_valid     <= req_valid;
      intack_strobe <= req_valid && sel[S_ACK];
      if (req_valid) begin
        dec_sel   <= sel;
        dec_addr  <= xaddr;
        dec_write <= req_write;
        dec_size  <= req_size;
      end
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid);
  assert_idle_follows_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dec_valid);
  assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $countones(dec_sel) == 1);
  assert_ack_read_byte_R6: assert property (@(posedge clk) disable iff (rst)
    intack_strobe |-> dec_valid && dec_sel[S_ACK] && !dec_write && dec_size == 2'b00);
  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_sel[S_ACK] |-> intack_strobe);
  assert_rom_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_sel[S_ROM] |-> !dec_write);
  assert_cfg_dev_range_R4: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_sel[S_CFG] |-> dec_addr[31:16] == 16'b0 && dec_addr[15:11] <= 5'(DEVBITS));
  assert_sparse_pack_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid && io_sparse && req_size != 2'b11 && req_addr[31:23] == 9'h100
    |=> dec_sel[S_IO] && dec_addr[15:5] == $past(req_addr[22:12])
        && dec_addr[4:0] == $past(req_addr[4:0]));
endmodule

// File: tb/hb_cpu_decoder_tb_top.sv
`timescale 1ns/1ps
module hb_cpu_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, io_sparse;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        dec_valid, dec_write, intack_strobe;
  logic [5:0]  dec_sel;
  logic [31:0] dec_addr;
  logic [1:0]  dec_size;

  int checks = 0, fails = 0;
  bit finished = 0;

  bit          e_valid, e_write, e_ack;
  int          e_tgt;
  longint      e_addr;
  logic [1:0]  e_size;
  string       e_tag;

  always #2.5 clk = ~clk;

  hb_cpu_decoder dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .io_sparse(io_sparse),
    .dec_valid(dec_valid), .dec_sel(dec_sel), .dec_addr(dec_addr),
    .dec_write(dec_write), .dec_size(dec_size), .intack_strobe(intack_strobe)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model(input longint a, input bit w, input int sz, input bit sp);
    e_ack = 0; e_addr = 0;
    if (sz == 3) begin e_tgt = 5; e_tag = "R9"; end
    else if (a >= 64'h8080_0000 && a < 64'h80C0_0000) begin
      int d = 0;
      while (d < 11 && ((a >> (11 + d)) % 2) == 0) d++;
      e_tgt = 1; e_addr = (a % 2048) + d * 2048;
      e_tag = (d == 11) ? "R5" : "R4";
    end else if (a >= 64'h8000_0000 && a < 64'h8080_0000) begin
      longint off = a - 64'h8000_0000;
      e_tgt = 0;
      if (sp) begin e_addr = (off % 32) + (off / 4096) * 32; e_tag = "R3"; end
      else begin e_addr = off % 65536; e_tag = "R2"; end
    end else if (a >= 64'h8000_0000 && a < 64'hBF80_0000) begin
      e_tgt = 0; e_addr = a - 64'h8000_0000; e_tag = "R1";
    end else if (a == 64'hBFFF_FFF0) begin
      e_tag = "R6";
      if (!w && sz == 0) begin e_tgt = 2; e_ack = 1; end else e_tgt = 5;
    end else if (a >= 64'hC000_0000 && a < 64'hFF00_0000) begin
      e_tgt = 3; e_addr = a - 64'hC000_0000; e_tag = "R7";
    end else if (a >= 64'hFFF0_0000) begin
      e_tag = "R8";
      if (w) e_tgt = 5; else begin e_tgt = 4; e_addr = a - 64'hFFF0_0000; end
    end else begin e_tgt = 5; e_tag = "R9"; end
  endtask

  task automatic compare();
    chk("R10 valid", dec_valid, e_valid);
    chk("R6 strobe", intack_strobe, e_valid && e_ack);
    if (e_valid) begin
      chk({"R11 select ", e_tag}, dec_sel, 64'd1 << e_tgt);
      chk({e_tag, " address"}, dec_addr, e_addr);
      chk("R10 write", dec_write, e_write);
      chk("R10 size", dec_size, e_size);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] a, input bit w,
                      input logic [1:0] sz, input bit sp);
    @(negedge clk);
    compare();
    req_valid = v; req_addr = a; req_write = w; req_size = sz; io_sparse = sp;
    e_valid = v; e_write = w; e_size = sz;
    if (v) model({32'b0, a}, w, int'(sz), sp);
  endtask

  task automatic rd(input logic [31:0] a, input bit sp = 0);
    step(1, a, 0, 2'd2, sp);
  endtask

  initial begin
    rst = 1; req_valid = 0; req_addr = 0; req_write = 0; req_size = 0; io_sparse = 0;
    e_valid = 0; e_write = 0; e_size = 0; e_ack = 0; e_tgt = 5; e_addr = 0; e_tag = "R9";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R10 reset valid", dec_valid, 0);
    chk("R10 reset select", dec_sel, 0);
    chk("R10 reset strobe", intack_strobe, 0);
    // R1 general I/O and window edges
    rd(32'h80C0_0000); rd(32'hBF7F_FFFF); rd(32'hBF80_0000); rd(32'h9234_5678);
    // R2 dense low window
    rd(32'h8000_0000); rd(32'h807F_FFFF); rd(32'h8012_3456);
    // R3 sparse, unaligned, mode toggling per request
    rd(32'h8012_3457, 1); rd(32'h8012_3457, 0); rd(32'h807F_FFFF, 1);
    step(1, 32'h8000_1003, 1, 2'd1, 1); rd(32'h8000_1003, 0);
    // R4/R5 configuration
    rd(32'h8080_0800); rd(32'h80A0_0000); rd(32'h80BF_F8FF); rd(32'h8080_07FF);
    rd(32'h80A0_1234); rd(32'h80BF_FFFF); rd(32'h80C0_0000);
    // R6 interrupt acknowledge
    step(1, 32'hBFFF_FFF0, 0, 2'd0, 0);
    step(1, 32'hBFFF_FFF0, 1, 2'd0, 0);
    step(1, 32'hBFFF_FFF0, 0, 2'd1, 0);
    step(1, 32'hBFFF_FFF1, 0, 2'd0, 0);
    step(1, 32'hBFFF_FFF0, 0, 2'd0, 0);
    step(0, 32'hBFFF_FFF0, 0, 2'd0, 0);
    // R7 memory
    rd(32'hC000_0000); rd(32'hFEFF_FFFF); rd(32'hFF00_0000); rd(32'hBFFF_FFFF);
    // R8 ROM
    rd(32'hFFF0_0000); rd(32'hFFFF_FFFF); rd(32'hFFEF_FFFF);
    step(1, 32'hFFF1_2345, 1, 2'd2, 0);
    // R9 unmapped
    rd(32'h7FFF_FFFF); rd(32'h0000_0000); step(1, 32'hC000_0000, 0, 2'd3, 0);
    step(1, 32'h8080_0800, 1, 2'd3, 1);
    // R10 gaps
    step(0, 32'h8000_0000, 0, 0, 0); step(0, 0, 0, 0, 0);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra = $urandom;
      if (k % 3 == 0) ra[31:24] = 8'h80;
      if (k % 5 == 0) ra[31:20] = 12'hFFF;
      step(($urandom % 4) != 0, ra, $urandom % 2, 2'($urandom % 4), $urandom % 2);
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule